// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block derives the two timing strobes a UART needs from one programmable divider value. A receive oversampling strobe paces the receiver's sampling logic. A transmit bit strobe marks each bit boundary for the transmitter. The divider value is a 16-bit word with a 12-bit integer part in bits 15:4 and a 4-bit fraction in bits 3:0. The fraction is realised by a per-side accumulator that lengthens an oversample period by one clock each time it wraps. Over many periods the average divisor then comes out as mantissa plus fraction/16, or mantissa plus fraction/8 when the 8x mode is selected.

Each direction has its own counter. The receive counter runs only while the receive enable is high, and the transmit counter runs only while the transmit enable is high. The transmit side counts its own oversample periods and emits one bit strobe every 16 of them in 16x mode, or every 8 in 8x mode. A new divider value is not applied partway through a period. Each side adopts it at its own next period end, or at once while that side is disabled.

Top module: `uart_baud_gen`

## Requirements
- R1: `div_q` is zero after reset. A cycle with `div_wr` high stores all 16 bits of `div_wdata`, and they are visible on `div_q` in the following cycle.
- R2: In 16x mode (`over8` = 0), each oversample period lasts M clocks when the 4-bit accumulator plus the fraction stays below 16, and M+1 clocks when it reaches 16 or more. The accumulator then keeps the sum modulo 16. M is bits 15:4 of the divider.
- R3: In 8x mode (`over8` = 1), fraction bit 3 has no effect. The 3-bit fraction in bits 2:0 is added to a 3-bit accumulator, and a carry out of 8 lengthens the period to M+1.
- R4: A mantissa of zero gives the same periods as a mantissa of one.
- R5: `tx_bit_tick` pulses for one cycle at the end of every 16th transmit oversample period in 16x mode, and at the end of every 8th in 8x mode.
- R6: While an enable is low, that side's period counter, accumulator and bit counter stay at zero, and its output strobe is low in the next cycle.
- R7: If an enable is high from cycle k onward after being low, that side's first oversample period ends with its strobe in cycle k+L, where L is the length of the first period.
- R8: A stored divider value is adopted at the next period end of each enabled side, and the accumulator is cleared at that point. A write made in the same cycle as a period end takes effect at the following period end. A disabled side adopts the value one cycle after it is stored.
- R9: The mode input `over8` is sampled at every period end and in every cycle while the side is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | 16 | Divider value to store: mantissa in bits 15:4, fraction in bits 3:0 |
| div_q | output | 16 | Stored divider value |
| over8 | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| tx_en | input | 1 | Transmit counter enable |
| rx_en | input | 1 | Receive counter enable |
| rx_os_tick | output | 1 | One-cycle receive oversample strobe |
| tx_bit_tick | output | 1 | One-cycle transmit bit strobe |

## Verification
A divider write can fall in the same cycle as a period end on either side. In that case the old value must still govern the period that starts there, and the write must stay pending until the next period end. The bench issues writes at intervals of one to six cycles, so these writes slide across every phase of short periods and repeatedly land on period ends of both sides. A behavioural reference model predicts every strobe and is compared with the design on every cycle. Enable edges that coincide with writes or mode changes are judged the same way.

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     div_wr,
  input  logic [MANT_W+FRAC_W-1:0] div_wdata,
  output logic [MANT_W+FRAC_W-1:0] div_q,
  input  logic                     over8,
  input  logic                     tx_en,
  input  logic                     rx_en,
  output logic                     rx_os_tick,
  output logic                     tx_bit_tick
);
  localparam int DIV_W = MANT_W + FRAC_W;

  logic [DIV_W-1:0] div_r;
  logic [1:0]       en;

  assign div_q = div_r;
  assign en    = {tx_en, rx_en};

  always_ff @(posedge clk) begin
    if (!rst_n)      div_r <= '0;
    else if (div_wr) div_r <= div_wdata;
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [MANT_W-1:0] mant, mant_eff;
    logic [FRAC_W-1:0] frac, acc, acc_nxt;
    logic [MANT_W:0]   cnt, last;
    logic [FRAC_W:0]   sum;
    logic              o8, pend, carry, boundary;

    assign mant_eff = (mant == '0) ? MANT_W'(1) : mant;

    always_comb begin
      if (o8) begin
        sum     = {2'b00, acc[FRAC_W-2:0]} + {2'b00, frac[FRAC_W-2:0]};
        carry   = sum[FRAC_W-1];
        acc_nxt = {1'b0, sum[FRAC_W-2:0]};
      end else begin
        sum     = {1'b0, acc} + {1'b0, frac};
        carry   = sum[FRAC_W];
        acc_nxt = sum[FRAC_W-1:0];
      end
    end

    assign last     = {1'b0, mant_eff} + {{MANT_W{1'b0}}, carry} - {{MANT_W{1'b0}}, 1'b1};
    assign boundary = en[s] && (cnt == last);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        acc  <= '0;
        mant <= '0;
        frac <= '0;
        o8   <= 1'b0;
        pend <= 1'b0;
      end else begin
        if (!en[s]) begin
          cnt  <= '0;
          acc  <= '0;
          mant <= div_r[DIV_W-1:FRAC_W];
          frac <= div_r[FRAC_W-1:0];
          o8   <= over8;
        end else if (boundary) begin
          cnt <= '0;
          o8  <= over8;
          if (pend) begin
            mant <= div_r[DIV_W-1:FRAC_W];
            frac <= div_r[FRAC_W-1:0];
            acc  <= '0;
          end else begin
            acc <= acc_nxt;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (div_wr)                  pend <= 1'b1;
        else if (!en[s] || boundary) pend <= 1'b0;
      end
    end

    if (s == 0) begin : g_os
      logic tick_q;
      always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= boundary;
      end
      assign rx_os_tick = tick_q;
    end else begin : g_bit
      logic [3:0] bc;
      logic       bit_last, bit_q;
      assign bit_last = o8 ? (bc >= 4'd7) : (bc == 4'd15);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bc    <= '0;
          bit_q <= 1'b0;
        end else begin
          bit_q <= boundary && bit_last;
          if (!en[s])        bc <= '0;
          else if (boundary) bc <= bit_last ? 4'd0 : bc + 4'd1;
        end
      end
      assign tx_bit_tick = bit_q;
    end
  end
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_wr,
  input logic [DIV_W-1:0] div_wdata,
  input logic [DIV_W-1:0] div_q,
  input logic             tx_en,
  input logic             rx_en,
  input logic             rx_os_tick,
  input logic             tx_bit_tick
);
  // R1
  div_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> div_q == $past(div_wdata));
  // R6
  rx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_os_tick);
  // R6
  tx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_bit_tick);
  // R7
  tx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |=> !tx_bit_tick);
  // R5
  bit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_tick |=> !tx_bit_tick);
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.DIV_W(MANT_W + FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata), .div_q(div_q),
  .tx_en(tx_en), .rx_en(rx_en), .rx_os_tick(rx_os_tick), .tx_bit_tick(tx_bit_tick)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_wr = 1'b0;
  logic [15:0] div_wdata = '0;
  logic [15:0] div_q;
  logic        over8 = 1'b0;
  logic        tx_en = 1'b0;
  logic        rx_en = 1'b0;
  logic        rx_os_tick, tx_bit_tick;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";

  uart_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata), .div_q(div_q),
    .over8(over8), .tx_en(tx_en), .rx_en(rx_en),
    .rx_os_tick(rx_os_tick), .tx_bit_tick(tx_bit_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: index 0 receive, index 1 transmit
  int m_div;
  int m_cnt[2], m_acc[2], m_mant[2], m_frac[2], m_o8[2], m_pend[2], m_bc[2];
  bit e_rx, e_bit;

  always @(posedge clk) begin
    bit en_s;
    if (!rst_n) begin
      m_div = 0; e_rx = 0; e_bit = 0;
      for (int s = 0; s < 2; s++) begin
        m_cnt[s] = 0; m_acc[s] = 0; m_mant[s] = 0; m_frac[s] = 0;
        m_o8[s] = 0; m_pend[s] = 0; m_bc[s] = 0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        int mm, fm, md, len;
        bit tick, fire;
        en_s = (s == 0) ? rx_en : tx_en;
        tick = 0; fire = 0;
        if (!en_s) begin
          m_cnt[s] = 0; m_acc[s] = 0; m_bc[s] = 0;
          m_mant[s] = m_div / 16; m_frac[s] = m_div % 16; m_o8[s] = over8;
          m_pend[s] = 0;
        end else begin
          mm  = (m_mant[s] == 0) ? 1 : m_mant[s];
          md  = m_o8[s] ? 8 : 16;
          fm  = m_frac[s] % md;
          len = mm + (((m_acc[s] + fm) >= md) ? 1 : 0);
          if (m_cnt[s] == len - 1) begin
            tick = 1;
            fire = (m_bc[s] >= md - 1);
            m_bc[s] = fire ? 0 : m_bc[s] + 1;
            m_cnt[s] = 0;
            m_acc[s] = (m_acc[s] + fm) % md;
            m_o8[s] = over8;
            if (m_pend[s]) begin
              m_mant[s] = m_div / 16; m_frac[s] = m_div % 16; m_acc[s] = 0; m_pend[s] = 0;
            end
          end else begin
            m_cnt[s]++;
          end
        end
        if (s == 0) e_rx = tick; else e_bit = tick && fire;
      end
      if (div_wr) begin
        m_div = div_wdata;
        m_pend[0] = 1; m_pend[1] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks += 3;
      if (rx_os_tick !== e_rx) begin
        fails++;
        $display("FAIL %s rx_os_tick actual %b expected %b at %0t", cur_req, rx_os_tick, e_rx, $time);
      end
      if (tx_bit_tick !== e_bit) begin
        fails++;
        $display("FAIL %s tx_bit_tick actual %b expected %b at %0t", cur_req, tx_bit_tick, e_bit, $time);
      end
      if (div_q !== 16'(m_div)) begin
        fails++;
        $display("FAIL %s div_q actual %h expected %h at %0t", cur_req, div_q, 16'(m_div), $time);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v);
    div_wr = 1'b1; div_wdata = v;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    checks++;
    if (div_q !== 16'h0 || rx_os_tick !== 1'b0 || tx_bit_tick !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state actual %h/%b/%b expected 0000/0/0", div_q, rx_os_tick, tx_bit_tick);
    end

    cur_req = "R2";
    wr(16'h0028);
    rx_en = 1'b1; tx_en = 1'b1;
    cyc(300);
    wr(16'h0037);
    cyc(400);

    cur_req = "R7";
    rx_en = 1'b0; tx_en = 1'b0;
    cyc(3);
    rx_en = 1'b1; cyc(5); tx_en = 1'b1;
    cyc(200);

    cur_req = "R8";
    wr(16'h0011);
    for (int i = 0; i < 60; i++) begin
      wr(16'h0010 + 16'((i * 7) % 48));
      cyc(i % 6);
    end
    cyc(200);

    cur_req = "R3";
    rx_en = 1'b0; tx_en = 1'b0;
    over8 = 1'b1;
    wr(16'h003F);
    cyc(2);
    rx_en = 1'b1; tx_en = 1'b1;
    cyc(400);
    wr(16'h0025);
    cyc(300);

    cur_req = "R4";
    wr(16'h0005);
    cyc(150);
    over8 = 1'b0;
    wr(16'h000B);
    cyc(250);

    cur_req = "R5";
    wr(16'h0010);
    cyc(300);

    cur_req = "R6";
    for (int i = 0; i < 40; i++) begin
      rx_en = (i % 3) != 0;
      tx_en = (i % 5) < 3;
      cyc(1 + (i % 7));
    end
    rx_en = 1'b1; tx_en = 1'b1;
    cyc(100);

    cur_req = "R9";
    rx_en = 1'b0;
    over8 = 1'b1; wr(16'h0029);
    cyc(2);
    rx_en = 1'b1;
    cyc(300);
    rx_en = 1'b0; tx_en = 1'b0;
    over8 = 1'b0;
    cyc(2);
    rx_en = 1'b1; tx_en = 1'b1;
    cyc(600);

    summary();
  end
endmodule